// File: doc/BRIEF.md
# Triggered One-Pulse PWM Timer

This block is a single PWM timer channel that waits idle until a rising edge on its trigger input, typically the update strobe of another timer. It then plays out a burst of one or more PWM periods and stops on its own. A free-running prescaler paces the counter, and the counter runs up or down between zero and an auto-reload limit. A compare value and a mode select form a reference level. A polarity inverter and two enables then shape that level into the pin.

Period length, prescale ratio, burst length and direction sit in shadow registers. The compare value can also sit in a shadow register when preload is selected. Shadow registers change only on an update event, which is either the end of the last period of a burst or a software update request. All configuration arrives on plain ports, and a burst is armed by pulsing the trigger.

Top module: `tpw_timer`

## Requirements
- R1: After reset the timer is idle (`running` = 0), `cnt_out` = 0, `update_evt` = 0, and every shadow value (prescale, limit, repeat, direction, compare) is 0.
- R2: A rising edge on `trig_in` while idle sets `running` at the next clock edge and loads the counter with 0 when counting up or with the active limit when counting down. A trigger edge while running is ignored, and a trigger held high does not start a second burst.
- R3: While running, the counter steps once every active-prescale+1 clocks. One period is limit+1 steps: up from 0 to the limit, or down from the limit to 0.
- R4: A burst is exactly repeat+1 periods. At the end of the last period `update_evt` is high for one cycle, `running` drops and the counter parks at 0.
- R5: In mode 1 (`cfg_mode2` = 0) the reference is active while counter < compare when counting up, and while counter <= compare when counting down.
- R6: Mode 2 (`cfg_mode2` = 1) gives the inverse of the mode 1 reference in both directions.
- R7: `cfg_invert` = 1 inverts the reference on its way to the pin, so mode 1 with inversion drives the same pin as mode 2 without it.
- R8: `pwm_out` is 0 whenever `ch_en` or `main_en` is 0, whatever the reference.
- R9: A `sw_update` pulse clears the prescaler and loads every shadow from the configuration ports. It sets the counter to 0, or to the new limit if the timer is running downward. It raises `update_evt` in the same cycle.
- R10: With `cfg_preload` = 1 the compare value used is the shadow copy taken at the last update event. With `cfg_preload` = 0 the `cfg_cmp` port is used immediately.
- R11: Changes to prescale, limit, repeat count and direction have no effect until the next update event.
- R12: A `sw_update` in the same cycle as a trigger edge while idle starts the burst with the newly loaded values. A `sw_update` in a cycle where the prescaler ticks replaces that counter step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_psc | input | PSC_W | Prescale ratio minus one |
| cfg_arr | input | CNT_W | Auto-reload limit |
| cfg_cmp | input | CNT_W | Compare value |
| cfg_rep | input | REP_W | Extra periods per burst |
| cfg_dir_down | input | 1 | 1 = count down |
| cfg_mode2 | input | 1 | 1 = PWM mode 2 |
| cfg_invert | input | 1 | 1 = invert reference at the pin |
| cfg_preload | input | 1 | 1 = compare taken from shadow |
| ch_en | input | 1 | Channel output enable |
| main_en | input | 1 | Main output enable |
| sw_update | input | 1 | Software update request (one-cycle pulse) |
| trig_in | input | 1 | Start trigger, rising edge |
| pwm_out | output | 1 | PWM pin |
| running | output | 1 | Burst in progress |
| update_evt | output | 1 | Update event strobe |
| cnt_out | output | CNT_W | Counter value |

## Verification
A software update can land in the same cycle as another event in two ways. It can coincide with a trigger edge while the timer is idle. It can also coincide with a prescaler tick while a burst runs, including the tick that would end the last period. The bench provokes the first case by pulsing both inputs together. It provokes the second by setting the prescale ratio to one, so that every running cycle ticks, and issuing the update mid-burst. A behavioural reference model steps alongside the design and is compared every clock on the pin, the counter, the run flag and the update strobe. Any disagreement about which action won that cycle shows up at once.

// File: rtl/tpw_pkg.sv
package tpw_pkg;

  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;

  // Compare reference before the polarity stage.
  function automatic logic ref_level(input logic [31:0] cnt, input logic [31:0] cmp,
                                     input dir_e dir, input logic mode2);
    logic lvl;
    if (dir == DIR_DOWN) lvl = (cnt <= cmp);
    else                 lvl = (cnt <  cmp);
    return lvl ^ mode2;
  endfunction

  // Pin level from reference, inverter and the two enables.
  function automatic logic pin_level(input logic refl, input logic inv,
                                     input logic ch_en, input logic main_en);
    return ch_en & main_en & (refl ^ inv);
  endfunction

endpackage

// File: rtl/tpw_prescale.sv
module tpw_prescale #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [PSC_W-1:0] limit,
  output logic             tick
);
  logic [PSC_W-1:0] pc_q;

  assign tick = run & (pc_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pc_q <= '0;
    else if (clr || !run)     pc_q <= '0;
    else if (tick)            pc_q <= '0;
    else                      pc_q <= pc_q + 1'b1;
  end

  // R3
  pc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || clr) |=> (pc_q == '0));

endmodule

// File: rtl/tpw_counter.sv
module tpw_counter
  import tpw_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             sw_upd,
  input  logic [CNT_W-1:0] arr_act,
  input  logic [REP_W-1:0] rep_act,
  input  dir_e             dir_act,
  input  logic [CNT_W-1:0] arr_new,
  input  logic [REP_W-1:0] rep_new,
  input  dir_e             dir_new,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             fin
);
  logic [REP_W-1:0] rep_left;
  logic             at_end;
  logic             run_next_sw;

  assign at_end      = (dir_act == DIR_DOWN) ? (cnt == '0) : (cnt == arr_act);
  assign fin         = tick & at_end & (rep_left == '0) & ~sw_upd;
  assign run_next_sw = running | start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      running  <= 1'b0;
      rep_left <= '0;
    end else if (sw_upd) begin
      cnt      <= (run_next_sw && dir_new == DIR_DOWN) ? arr_new : '0;
      rep_left <= rep_new;
      running  <= run_next_sw;
    end else if (start) begin
      running  <= 1'b1;
      cnt      <= (dir_act == DIR_DOWN) ? arr_act : '0;
      rep_left <= rep_act;
    end else if (tick) begin
      if (at_end) begin
        if (rep_left == '0) begin
          running <= 1'b0;
          cnt     <= '0;
        end else begin
          rep_left <= rep_left - 1'b1;
          cnt      <= (dir_act == DIR_DOWN) ? arr_act : '0;
        end
      end else if (dir_act == DIR_DOWN) begin
        cnt <= cnt - 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt <= arr_act));

  // R4
  park_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> (cnt == '0));

  // R2
  start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> running);

endmodule

// File: rtl/tpw_outstage.sv
module tpw_outstage
  import tpw_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  dir_e             dir,
  input  logic             mode2,
  input  logic             invert,
  input  logic             ch_en,
  input  logic             main_en,
  input  logic             running,
  output logic             pin
);
  logic refl;

  assign refl = ref_level(32'(cnt), 32'(cmp), dir, mode2);
  assign pin  = pin_level(refl, invert, ch_en, main_en);

  // R4: parked at zero, mode 1 without inversion sits at the active level
  idle_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && ch_en && main_en && !invert && !mode2 && cmp != '0) |-> pin);

endmodule

// File: rtl/tpw_timer.sv
module tpw_timer
  import tpw_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] cfg_psc,
  input  logic [CNT_W-1:0] cfg_arr,
  input  logic [CNT_W-1:0] cfg_cmp,
  input  logic [REP_W-1:0] cfg_rep,
  input  logic             cfg_dir_down,
  input  logic             cfg_mode2,
  input  logic             cfg_invert,
  input  logic             cfg_preload,
  input  logic             ch_en,
  input  logic             main_en,
  input  logic             sw_update,
  input  logic             trig_in,
  output logic             pwm_out,
  output logic             running,
  output logic             update_evt,
  output logic [CNT_W-1:0] cnt_out
);
  logic [PSC_W-1:0] psc_act;
  logic [CNT_W-1:0] arr_act;
  logic [REP_W-1:0] rep_act;
  dir_e             dir_act;
  dir_e             dir_new;
  logic [CNT_W-1:0] cmp_shd;
  logic [CNT_W-1:0] cmp_eff;
  logic             trig_q;
  logic             trig_rise;
  logic             start;
  logic             tick;
  logic             fin;

  assign dir_new    = cfg_dir_down ? DIR_DOWN : DIR_UP;
  assign trig_rise  = trig_in & ~trig_q;
  assign start      = trig_rise & ~running;
  assign update_evt = sw_update | fin;
  assign cmp_eff    = cfg_preload ? cmp_shd : cfg_cmp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_act <= '0;
      arr_act <= '0;
      rep_act <= '0;
      dir_act <= DIR_UP;
      cmp_shd <= '0;
    end else if (update_evt) begin
      psc_act <= cfg_psc;
      arr_act <= cfg_arr;
      rep_act <= cfg_rep;
      dir_act <= dir_new;
      cmp_shd <= cfg_cmp;
    end
  end

  tpw_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(running), .clr(sw_update),
    .limit(psc_act), .tick(tick)
  );

  tpw_counter #(.CNT_W(CNT_W), .REP_W(REP_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .sw_upd(sw_update),
    .arr_act(arr_act), .rep_act(rep_act), .dir_act(dir_act),
    .arr_new(cfg_arr), .rep_new(cfg_rep), .dir_new(dir_new),
    .cnt(cnt_out), .running(running), .fin(fin)
  );

  tpw_outstage #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .cnt(cnt_out), .cmp(cmp_eff), .dir(dir_act),
    .mode2(cfg_mode2), .invert(cfg_invert), .ch_en(ch_en), .main_en(main_en),
    .running(running), .pin(pwm_out)
  );

  // R11
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !update_evt) |=> $stable(arr_act) && $stable(psc_act));

  // R9
  sw_reinit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_update |=> (cnt_out == '0) || (running && dir_act == DIR_DOWN));

endmodule

// File: tb/tpw_timer_test.sv
`timescale 1ns/1ps
module tpw_timer_test;
  localparam int CNT_W = 16;
  localparam int PSC_W = 16;
  localparam int REP_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PSC_W-1:0] cfg_psc = '0;
  logic [CNT_W-1:0] cfg_arr = '0;
  logic [CNT_W-1:0] cfg_cmp = '0;
  logic [REP_W-1:0] cfg_rep = '0;
  logic cfg_dir_down = 0, cfg_mode2 = 0, cfg_invert = 0, cfg_preload = 0;
  logic ch_en = 0, main_en = 0, sw_update = 0, trig_in = 0;
  logic pwm_out, running, update_evt;
  logic [CNT_W-1:0] cnt_out;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;
  string tag  = "R1";

  // reference model state
  int m_pc = 0, m_cnt = 0, m_rep = 0;
  int m_psc = 0, m_arr = 0, m_repa = 0, m_cmp = 0;
  bit m_run = 0, m_down = 0, m_trq = 0;

  always #10 clk = ~clk;

  tpw_timer #(.CNT_W(CNT_W), .PSC_W(PSC_W), .REP_W(REP_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_psc(cfg_psc), .cfg_arr(cfg_arr),
    .cfg_cmp(cfg_cmp), .cfg_rep(cfg_rep), .cfg_dir_down(cfg_dir_down),
    .cfg_mode2(cfg_mode2), .cfg_invert(cfg_invert), .cfg_preload(cfg_preload),
    .ch_en(ch_en), .main_en(main_en), .sw_update(sw_update), .trig_in(trig_in),
    .pwm_out(pwm_out), .running(running), .update_evt(update_evt), .cnt_out(cnt_out)
  );

  function automatic bit m_final();
    bit at_end;
    at_end = m_down ? (m_cnt == 0) : (m_cnt == m_arr);
    return !sw_update && m_run && (m_pc == m_psc) && at_end && (m_rep == 0);
  endfunction

  function automatic bit m_pin();
    int c;
    bit r;
    c = cfg_preload ? m_cmp : int'(cfg_cmp);
    r = m_down ? (m_cnt <= c) : (m_cnt < c);
    if (cfg_mode2) r = !r;
    if (cfg_invert) r = !r;
    return ch_en && main_en && r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0; m_cnt = 0; m_rep = 0; m_run = 0; m_trq = 0;
      m_psc = 0; m_arr = 0; m_repa = 0; m_cmp = 0; m_down = 0;
    end else begin
      bit start, tick, fin, nrun;
      start = trig_in && !m_trq && !m_run;
      tick  = m_run && (m_pc == m_psc);
      fin   = m_final();
      nrun  = m_run;
      if (sw_update) begin
        nrun  = m_run || start;
        m_cnt = (nrun && cfg_dir_down) ? int'(cfg_arr) : 0;
        m_rep = int'(cfg_rep);
      end else if (start) begin
        nrun  = 1;
        m_cnt = m_down ? m_arr : 0;
        m_rep = m_repa;
      end else if (tick) begin
        if (m_down ? (m_cnt == 0) : (m_cnt == m_arr)) begin
          if (m_rep == 0) begin nrun = 0; m_cnt = 0; end
          else begin m_rep--; m_cnt = m_down ? m_arr : 0; end
        end else m_cnt = m_down ? m_cnt - 1 : m_cnt + 1;
      end
      if (sw_update || !m_run || tick) m_pc = 0; else m_pc++;
      if (sw_update || fin) begin
        m_psc = int'(cfg_psc); m_arr = int'(cfg_arr); m_repa = int'(cfg_rep);
        m_down = cfg_dir_down; m_cmp = int'(cfg_cmp);
      end
      m_run = nrun;
      m_trq = trig_in;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (pwm_out !== m_pin()) begin
        errors++;
        $display("FAIL %s pwm_out act=%b exp=%b t=%0t", tag, pwm_out, m_pin(), $time);
      end
      if (int'(cnt_out) != m_cnt) begin
        errors++;
        $display("FAIL %s cnt_out act=%0d exp=%0d t=%0t", tag, cnt_out, m_cnt, $time);
      end
      if (running !== m_run) begin
        errors++;
        $display("FAIL %s running act=%b exp=%b t=%0t", tag, running, m_run, $time);
      end
      if (update_evt !== (sw_update || m_final())) begin
        errors++;
        $display("FAIL %s update_evt act=%b exp=%b t=%0t", tag, update_evt,
                 sw_update || m_final(), $time);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_sw();
    sw_update = 1; step(1); sw_update = 0;
  endtask

  task automatic pulse_trig();
    trig_in = 1; step(1); trig_in = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && running; i++) step(1);
  endtask

  initial begin
    step(3);
    // R1: reset state
    check(running == 0, "R1 running", running, 0);
    check(cnt_out == 0, "R1 cnt_out", cnt_out, 0);
    check(pwm_out == 0, "R1 pwm_out", pwm_out, 0);
    rst_n = 1;
    step(2);

    // R2 R3 R4 R5: up, prescale 3, limit 9, two periods
    tag = "R5";
    cfg_psc = 2; cfg_arr = 9; cfg_cmp = 4; cfg_rep = 1; ch_en = 1; main_en = 1;
    pulse_sw();
    step(3);
    check(pwm_out == 1, "R4 idle level", pwm_out, 1);
    tag = "R2"; pulse_trig();
    check(running == 1, "R2 start", running, 1);
    step(20);
    tag = "R2"; pulse_trig(); step(5);           // ignored while running
    trig_in = 1; step(2);                        // held high
    tag = "R4"; wait_idle();
    check(cnt_out == 0, "R4 park", cnt_out, 0);
    step(10);
    check(running == 0, "R2 held trigger no restart", running, 1'b0);
    trig_in = 0; step(2);

    // R6 R7: mode 2, then mode 1 with inversion
    tag = "R6"; cfg_mode2 = 1; pulse_trig(); wait_idle();
    tag = "R7"; cfg_mode2 = 0; cfg_invert = 1; pulse_trig(); wait_idle();

    // R8: enables dropped mid-burst
    tag = "R8"; cfg_invert = 0; pulse_trig(); step(7);
    ch_en = 0; step(6);
    check(pwm_out == 0, "R8 ch_en low", pwm_out, 0);
    ch_en = 1; main_en = 0; step(6);
    check(pwm_out == 0, "R8 main_en low", pwm_out, 0);
    main_en = 1; wait_idle();

    // R11: new limit/direction wait for update; then down counting
    tag = "R11"; cfg_arr = 5; cfg_dir_down = 1; pulse_trig(); step(10);
    check(running == 1, "R11 old limit kept", running, 1);
    wait_idle();
    tag = "R5"; cfg_rep = 2; pulse_trig(); wait_idle();

    // R10: compare change mid-burst, preload off then on
    tag = "R10"; cfg_dir_down = 0; cfg_psc = 1; cfg_arr = 15; cfg_rep = 0;
    pulse_sw();
    pulse_trig(); step(6); cfg_cmp = 12; step(10); wait_idle();
    cfg_preload = 1; pulse_trig(); step(6); cfg_cmp = 3; step(10); wait_idle();
    pulse_trig(); wait_idle();
    cfg_preload = 0;

    // R9: software update mid-burst, up and down
    tag = "R9"; pulse_trig(); step(9); pulse_sw();
    check(cnt_out == 0, "R9 reinit up", cnt_out, 0);
    wait_idle();
    cfg_dir_down = 1; cfg_arr = 7; pulse_sw();
    pulse_trig(); step(5); pulse_sw();
    check(cnt_out == 7, "R9 reinit down", cnt_out, 7);
    wait_idle();

    // R12: sw update with trigger while idle; sw update on a tick
    tag = "R12"; cfg_dir_down = 0; cfg_arr = 4; cfg_psc = 0; cfg_rep = 1;
    trig_in = 1; sw_update = 1; step(1); trig_in = 0; sw_update = 0;
    check(running == 1, "R12 joint start", running, 1);
    step(3); pulse_sw();
    check(cnt_out == 0, "R12 sw beats tick", cnt_out, 0);
    wait_idle();
    step(4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule